// File: doc/BRIEF.md
# SPI Flash Command Sequencer

This block is a register-programmed host for a serial flash device. Software fills a small table of eight one-byte opcodes. It gives each table entry a two-bit type that says whether the command carries a 24-bit address and in which direction its data moves. It also programs two prefix opcodes. Each command is then started by one write to the control register. That write picks a table entry, optionally asks for a data phase of 1 to 64 bytes through a 64-byte buffer, and optionally asks for an atomic sequence. In an atomic sequence the chosen prefix opcode goes out in its own chip-select frame just before the main command.

The serial side runs SPI mode 0. SCK idles low, MOSI is set up before each rising edge, and MISO is sampled on the rising edge. SCK runs at the system clock divided by `CLK_DIV`. A sticky lock bit freezes the opcode table, the types and the prefixes until reset. A start request that selects an empty table entry (opcode 0x00) is refused and flagged.

The register window is word addressed and uses a 16-bit write port and a combinational read port:

| Address | Contents |
|---|---|
| 0x00 | status |
| 0x01 | control |
| 0x02 | address[15:0] |
| 0x03 | address[23:16] |
| 0x04 | prefixes |
| 0x05 | types |
| 0x08+i | table entry i |
| 0x40+j | buffer byte j |

Top module: `spi_seq_ctrl`

## Requirements
- R1: After reset the status register reads 0x0000, `spi_cs_n` is high, `spi_sck` is low, and every table entry reads 0x00.
- R2: A control write with bit 1 (start) set, made while idle and selecting a non-zero entry, starts a cycle. Status bit 0 (in progress) reads 1 from the next clock. The control fields are: bit 2 atomic, bit 3 prefix select, bits [6:4] entry index, bits [13:8] byte count minus one, bit 14 data-cycle enable. The control register reads back as written, with bit 1 clear.
- R3: Each frame sends the opcode byte first. If the entry type has an address, the address register follows in three bytes, bits 23..0. The data phase comes last. Every byte is sent MSB first. SCK is low whenever `spi_cs_n` is high.
- R4: The type of entry i sits in bits [2i+1:2i] of register 0x05. The encodings are 00 read without address, 01 write without address, 10 read with address and 11 write with address. Write types send buffer bytes 0 upward. Read types send 0x00 and store the received bytes into buffer bytes 0 upward.
- R5: With bit 14 set, the data phase moves exactly (bits [13:8] + 1) bytes, 1 to 64. With bit 14 clear, there is no data phase.
- R6: Register 0x04 holds prefix 0 in bits [7:0] and prefix 1 in bits [15:8]. An atomic request sends the selected prefix alone in one frame, then the main command in a second frame, and nothing else between them. `spi_cs_n` stays high for at least one SCK period (`CLK_DIV` clocks) between the two frames.
- R7: A start request whose entry holds 0x00 causes no chip-select activity. It sets status bit 2 (blocked) and leaves the in-progress flag at 0.
- R8: A control write made while a cycle is in progress is ignored. It starts no new frame and does not change the control register.
- R9: The in-progress flag falls in the same clock that status bit 1 (done) rises. Writing 1 to status bit 1 or bit 2 clears that flag.
- R10: Writing 1 to status bit 15 sets the lock. Once locked, writes to the table, the types and the prefixes have no effect. Only reset clears the lock.
- R11: While `spi_cs_n` is low, every SCK high phase and every SCK low phase lasts `CLK_DIV/2` clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Register read data (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the block with `CLK_DIV` = 4 and `GAP_SCK` = 1. This gives two-clock SCK phases and a four-clock minimum chip-select gap, so a full 68-byte frame stays short while phase lengths and the inter-frame gap can still be told apart from off-by-one errors. A behavioural flash model captures MOSI bits and returns a known byte pattern on MISO. With it, the bench covers all four entry types, the 1-byte and 64-byte data-phase extremes, both prefixes in atomic mode, a refused empty entry and a start written during a busy cycle.

// File: rtl/spi_seq_pkg.sv
// Shared definitions for the SPI command sequencer: register map,
// status/control bit positions, entry type encoding and sequencer states.
package spi_seq_pkg;

    typedef enum logic [1:0] {
        TY_RD      = 2'b00,
        TY_WR      = 2'b01,
        TY_RD_ADDR = 2'b10,
        TY_WR_ADDR = 2'b11
    } op_type_e;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_SHIFT,
        SQ_GAP
    } seq_state_e;

    localparam logic [7:0] A_STATUS  = 8'h00;
    localparam logic [7:0] A_CTRL    = 8'h01;
    localparam logic [7:0] A_ADDR_LO = 8'h02;
    localparam logic [7:0] A_ADDR_HI = 8'h03;
    localparam logic [7:0] A_PREFIX  = 8'h04;
    localparam logic [7:0] A_TYPES   = 8'h05;
    localparam logic [7:0] A_MENU    = 8'h08;
    localparam logic [7:0] A_DATA    = 8'h40;

    localparam int ST_BUSY  = 0;
    localparam int ST_DONE  = 1;
    localparam int ST_BLOCK = 2;
    localparam int ST_LOCK  = 15;

    localparam int C_GO   = 1;
    localparam int C_ATOM = 2;
    localparam int C_PSEL = 3;
    localparam int C_DATA = 14;

endpackage

// File: rtl/spi_seq_cfg.sv
// Configuration bank: opcode table, per-entry types, prefix pair and the
// sticky lock. Assumes the table has 8 entries so the types fit 16 bits.
module spi_seq_cfg
    import spi_seq_pkg::*;
#(
    parameter int MENU_N = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [7:0]          wr_addr,
    input  logic [15:0]         wr_data,
    input  logic                lock_set,
    output logic [MENU_N*8-1:0] menu_flat,
    output logic [2*MENU_N-1:0] types,
    output logic [15:0]         prefixes,
    output logic                lock
);

    logic [7:0] menu_q [MENU_N];

    // Holds the table, types and prefixes; writes are dropped once locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lock     <= 1'b0;
            types    <= '0;
            prefixes <= '0;
            for (int i = 0; i < MENU_N; i++) menu_q[i] <= '0;
        end else begin
            if (lock_set) lock <= 1'b1;
            if (wr_en && !lock) begin
                if (wr_addr == A_TYPES)  types    <= wr_data[2*MENU_N-1:0];
                if (wr_addr == A_PREFIX) prefixes <= wr_data;
                for (int i = 0; i < MENU_N; i++)
                    if (wr_addr == A_MENU + 8'(i)) menu_q[i] <= wr_data[7:0];
            end
        end
    end

    for (genvar g = 0; g < MENU_N; g++) begin : g_flat
        assign menu_flat[g*8 +: 8] = menu_q[g];
    end

endmodule

// File: rtl/spi_seq_shifter.sv
// Mode-0 byte shifter: sends one byte MSB first and captures one byte.
// A start in the same clock as done chains the next byte with no gap.
// Assumes HALF >= 1 system clocks per SCK phase.
module spi_seq_shifter #(
    parameter int HALF = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] tx_byte,
    input  logic       miso,
    output logic       sck,
    output logic       mosi,
    output logic [7:0] rx_byte,
    output logic       done
);

    localparam int HC_W = (HALF > 1) ? $clog2(HALF) : 1;

    logic            active;
    logic [7:0]      tx_sh;
    logic [2:0]      bit_cnt;
    logic [HC_W-1:0] hcnt;
    logic            tick;

    assign tick = active && (hcnt == HC_W'(HALF - 1));
    assign done = tick && sck && (bit_cnt == 3'd7);
    assign mosi = tx_sh[7];

    // Times SCK phases, shifts MOSI on falling edges, samples MISO on rising.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active  <= 1'b0;
            sck     <= 1'b0;
            tx_sh   <= '0;
            rx_byte <= '0;
            bit_cnt <= '0;
            hcnt    <= '0;
        end else if (start) begin
            active  <= 1'b1;
            sck     <= 1'b0;
            tx_sh   <= tx_byte;
            bit_cnt <= '0;
            hcnt    <= '0;
        end else if (active) begin
            if (tick) begin
                hcnt <= '0;
                if (!sck) begin
                    sck     <= 1'b1;
                    rx_byte <= {rx_byte[6:0], miso};
                end else begin
                    sck <= 1'b0;
                    if (bit_cnt == 3'd7) begin
                        active <= 1'b0;
                    end else begin
                        bit_cnt <= bit_cnt + 3'd1;
                        tx_sh   <= {tx_sh[6:0], 1'b0};
                    end
                end
            end else begin
                hcnt <= hcnt + HC_W'(1);
            end
        end
    end

endmodule

// File: rtl/spi_seq_ctrl.sv
// SPI flash command sequencer top: register window, 64-byte data buffer,
// frame sequencer (optional prefix frame, opcode, address, data) and a
// byte shifter. Assumes CLK_DIV is even and software does not rewrite the
// table while a cycle runs.
module spi_seq_ctrl
    import spi_seq_pkg::*;
#(
    parameter int CLK_DIV = 4,
    parameter int GAP_SCK = 1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [15:0] wr_data,
    input  logic [7:0]  rd_addr,
    output logic [15:0] rd_data,
    output logic        spi_cs_n,
    output logic        spi_sck,
    output logic        spi_mosi,
    input  logic        spi_miso
);

    localparam int MENU_N   = 8;
    localparam int BUF_N    = 64;
    localparam int HALF     = CLK_DIV / 2;
    localparam int GAP_CLKS = CLK_DIV * GAP_SCK;
    localparam int GAP_W    = $clog2(GAP_CLKS + 1);
    localparam int K_W      = 7;

    logic [MENU_N*8-1:0] menu_flat;
    logic [2*MENU_N-1:0] types;
    logic [15:0]         prefixes;
    logic                cfg_lock;

    seq_state_e  state_q;
    logic        busy_q, done_q, blocked_q, cs_n_q, in_pre;
    logic [15:0] ctrl_q;
    logic [23:0] addr_q;
    logic [K_W-1:0]   k_q;
    logic [GAP_W-1:0] gap_q;
    logic [7:0]  buf_q [BUF_N];

    logic [2:0]  sel_idx, cur_idx;
    logic [7:0]  sel_op, cur_op, launch_byte, main_byte, rx_byte;
    logic        sel_zero, go_req, launch, has_addr, is_wr;
    logic [1:0]  cur_type;
    logic [K_W-1:0] hdr, nbytes, last_k, nk;
    logic        sh_start, sh_done, sh_sck, sh_mosi;
    logic        gap_end, rx_store;

    spi_seq_cfg #(.MENU_N(MENU_N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data),
        .lock_set(wr_en && wr_addr == A_STATUS && wr_data[ST_LOCK]),
        .menu_flat(menu_flat), .types(types), .prefixes(prefixes),
        .lock(cfg_lock)
    );

    spi_seq_shifter #(.HALF(HALF)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx_byte(launch ? launch_byte : main_byte),
        .miso(spi_miso), .sck(sh_sck), .mosi(sh_mosi), .rx_byte(rx_byte),
        .done(sh_done)
    );

    // Decodes the start request and the fields of the running command.
    always_comb begin
        sel_idx     = wr_data[6:4];
        sel_op      = menu_flat[{sel_idx, 3'b000} +: 8];
        sel_zero    = (sel_op == 8'h00);
        go_req      = wr_en && (wr_addr == A_CTRL) && wr_data[C_GO] && !busy_q;
        launch      = go_req && !sel_zero;
        launch_byte = !wr_data[C_ATOM] ? sel_op :
                      (wr_data[C_PSEL] ? prefixes[15:8] : prefixes[7:0]);
        cur_idx     = ctrl_q[6:4];
        cur_op      = menu_flat[{cur_idx, 3'b000} +: 8];
        cur_type    = types[{cur_idx, 1'b0} +: 2];
        has_addr    = cur_type[1];
        is_wr       = cur_type[0];
        hdr         = has_addr ? K_W'(4) : K_W'(1);
        nbytes      = ctrl_q[C_DATA] ? ({1'b0, ctrl_q[13:8]} + K_W'(1)) : '0;
        last_k      = in_pre ? '0 : (hdr + nbytes - K_W'(1));
        gap_end     = (state_q == SQ_GAP) && (gap_q == GAP_W'(GAP_CLKS - 1));
        nk          = (state_q == SQ_GAP) ? '0 : (k_q + K_W'(1));
        sh_start    = launch || (state_q == SQ_SHIFT && sh_done && k_q != last_k)
                      || (gap_end && in_pre);
        rx_store    = (state_q == SQ_SHIFT) && sh_done && !in_pre && !is_wr && (k_q >= hdr);
    end

    // Picks the main-frame byte at position nk: opcode, address, then data.
    always_comb begin
        if (nk == '0)                  main_byte = cur_op;
        else if (has_addr && nk == 1)  main_byte = addr_q[23:16];
        else if (has_addr && nk == 2)  main_byte = addr_q[15:8];
        else if (has_addr && nk == 3)  main_byte = addr_q[7:0];
        else if (is_wr)                main_byte = buf_q[6'(nk - hdr)];
        else                           main_byte = 8'h00;
    end

    // Sequences frames and keeps status, control and address registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_IDLE;
            busy_q    <= 1'b0;
            done_q    <= 1'b0;
            blocked_q <= 1'b0;
            cs_n_q    <= 1'b1;
            in_pre    <= 1'b0;
            ctrl_q    <= '0;
            addr_q    <= '0;
            k_q       <= '0;
            gap_q     <= '0;
        end else begin
            if (wr_en && wr_addr == A_STATUS) begin
                if (wr_data[ST_DONE])  done_q    <= 1'b0;
                if (wr_data[ST_BLOCK]) blocked_q <= 1'b0;
            end
            if (wr_en && !busy_q) begin
                if (wr_addr == A_ADDR_LO) addr_q[15:0]  <= wr_data;
                if (wr_addr == A_ADDR_HI) addr_q[23:16] <= wr_data[7:0];
                if (wr_addr == A_CTRL)    ctrl_q <= wr_data & ~(16'd1 << C_GO);
            end
            if (go_req) begin
                if (sel_zero) begin
                    blocked_q <= 1'b1;
                end else begin
                    busy_q  <= 1'b1;
                    in_pre  <= wr_data[C_ATOM];
                    k_q     <= '0;
                    cs_n_q  <= 1'b0;
                    state_q <= SQ_SHIFT;
                end
            end
            case (state_q)
                SQ_SHIFT: if (sh_done) begin
                    if (k_q == last_k) begin
                        cs_n_q  <= 1'b1;
                        gap_q   <= '0;
                        state_q <= SQ_GAP;
                    end else begin
                        k_q <= k_q + K_W'(1);
                    end
                end
                SQ_GAP: if (gap_end) begin
                    if (in_pre) begin
                        in_pre  <= 1'b0;
                        k_q     <= '0;
                        cs_n_q  <= 1'b0;
                        state_q <= SQ_SHIFT;
                    end else begin
                        busy_q  <= 1'b0;
                        done_q  <= 1'b1;
                        state_q <= SQ_IDLE;
                    end
                end else begin
                    gap_q <= gap_q + GAP_W'(1);
                end
                default: ;
            endcase
        end
    end

    // Data buffer: received bytes take priority over bus writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < BUF_N; i++) buf_q[i] <= '0;
        end else if (rx_store) begin
            buf_q[6'(k_q - hdr)] <= rx_byte;
        end else if (wr_en && wr_addr[7:6] == A_DATA[7:6]) begin
            buf_q[wr_addr[5:0]] <= wr_data[7:0];
        end
    end

    // Register read mux.
    always_comb begin
        rd_data = '0;
        if (rd_addr[7:6] == A_DATA[7:6])       rd_data = {8'h00, buf_q[rd_addr[5:0]]};
        else if (rd_addr[7:3] == A_MENU[7:3])  rd_data = {8'h00, menu_flat[{rd_addr[2:0], 3'b000} +: 8]};
        else begin
            case (rd_addr)
                A_STATUS:  rd_data = {cfg_lock, 12'h000, blocked_q, done_q, busy_q};
                A_CTRL:    rd_data = ctrl_q;
                A_ADDR_LO: rd_data = addr_q[15:0];
                A_ADDR_HI: rd_data = {8'h00, addr_q[23:16]};
                A_PREFIX:  rd_data = prefixes;
                A_TYPES:   rd_data = types;
                default:   rd_data = '0;
            endcase
        end
    end

    assign spi_cs_n = cs_n_q;
    assign spi_sck  = sh_sck;
    assign spi_mosi = sh_mosi;

endmodule

// File: rtl/spi_seq_ctrl_chk.sv
// Protocol checker for spi_seq_ctrl, bound into every instance.
// Observes chip select, SCK, status state and the start decode.
module spi_seq_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic sck,
    input logic busy,
    input logic done,
    input logic blocked,
    input logic lock,
    input logic go_req,
    input logic sel_zero
);

    // R3: SCK stays low while the chip is deselected.
    a_r3_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R2: chip select is only driven low inside an accepted cycle.
    a_r2_cs_only_in_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> cs_n);

    // R9: the in-progress flag falls only together with done being set.
    a_r9_busy_to_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R7: a start on an empty entry is refused and flagged.
    a_r7_refused_empty: assert property (@(posedge clk) disable iff (!rst_n)
        (go_req && sel_zero) |=> (blocked && !busy));

    // R10: the lock never clears without reset.
    a_r10_lock_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> lock);

endmodule

bind spi_seq_ctrl spi_seq_ctrl_chk i_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sck(spi_sck),
    .busy(busy_q), .done(done_q), .blocked(blocked_q), .lock(cfg_lock),
    .go_req(go_req), .sel_zero(sel_zero)
);

// File: tb/test_spi_seq_ctrl.sv
// Bench for spi_seq_ctrl: behavioural flash model plus per-clock monitor.
module test_spi_seq_ctrl;

    localparam int CLK_PERIOD = 10;
    localparam int CLK_DIV    = 4;
    localparam int HALF       = CLK_DIV / 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic        spi_cs_n, spi_sck, spi_mosi, spi_miso;

    int n_chk = 0;
    int n_fail = 0;

    spi_seq_ctrl #(.CLK_DIV(CLK_DIV), .GAP_SCK(1)) i_spi_seq_ctrl (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] pat(int k);
        return 8'(k * 37 + 5);
    endfunction

    function automatic logic pbit(int p);
        logic [7:0] b;
        b = pat(p / 8);
        return b[7 - (p % 8)];
    endfunction

    // ---------------- flash model ----------------
    int         bitpos = 0;
    int         frame_bytes = 0;
    logic [7:0] sh = '0;
    logic [7:0] got_b[$];
    int         got_f[$];
    int         cyc = 0;
    int         last_rise = -1;
    int         min_gap = 1000000;

    assign spi_miso = pbit(bitpos);

    always @(posedge clk) cyc++;

    always @(negedge spi_cs_n) begin
        bitpos = 0;
        frame_bytes = 0;
        if (last_rise >= 0 && (cyc - last_rise) < min_gap) min_gap = cyc - last_rise;
    end

    always @(posedge spi_cs_n) begin
        if (rst_n) begin
            got_f.push_back(frame_bytes);
            last_rise = cyc;
        end
    end

    always @(posedge spi_sck) begin
        if (!spi_cs_n) begin
            sh = {sh[6:0], spi_mosi};
            bitpos++;
            if (bitpos % 8 == 0) begin
                got_b.push_back(sh);
                frame_bytes++;
            end
        end
    end

    // ---------------- per-clock monitor (R3, R11, R2) ----------------
    int   mon_err = 0;
    int   run = 0;
    logic prev_sck = 1'b0;
    logic prev_cs = 1'b1;
    bit   model_active = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (spi_cs_n && spi_sck) mon_err++;
            if (!model_active && !spi_cs_n) mon_err++;
            if (prev_cs && !spi_cs_n) run = 1;
            else if (spi_sck != prev_sck) begin
                if (!spi_cs_n && run != HALF) mon_err++;
                run = 1;
            end else run++;
        end
        prev_sck = spi_sck;
        prev_cs  = spi_cs_n;
    end

    // ---------------- helpers ----------------
    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    logic [7:0] exp_b[$];
    int         exp_f[$];

    // Starts a cycle, optionally writes a second start while busy, waits for done.
    task automatic run_cycle(input logic [15:0] ctrl, input bit extra, input string req);
        logic [15:0] st;
        bit seq_ok = 1'b1;
        bit prev_busy;
        got_b.delete(); got_f.delete();
        min_gap = 1000000; last_rise = -1;
        model_active = 1'b1;
        wr(8'h01, ctrl);
        rd(8'h00, st);
        check(st[0] == 1'b1, "R2 busy after start", int'(st), 1);
        if (extra) wr(8'h01, 16'h4032);
        prev_busy = 1'b1;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk);
            rd(8'h00, st);
            if (prev_busy && !st[0] && !st[1]) seq_ok = 1'b0;
            prev_busy = st[0];
            if (!st[0] && st[1]) break;
        end
        check(seq_ok && st[1] && !st[0], "R9 busy falls as done rises", int'(st), 2);
        model_active = 1'b0;
        check(got_f == exp_f, {req, " frame lengths"}, got_f.size(), exp_f.size());
        check(got_b == exp_b, {req, " frame bytes"}, got_b.size(), exp_b.size());
        wr(8'h00, 16'h0002);
    endtask

    // ---------------- stimulus ----------------
    initial begin
        logic [15:0] v;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(8'h00, v);  check(v == 16'h0000, "R1 status", int'(v), 0);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins idle", int'({spi_cs_n, spi_sck}), 2);
        rd(8'h0B, v);  check(v == 16'h0000, "R1 table entry", int'(v), 0);

        // table: 0 9F rd, 1 03 rd+addr, 2 02 wr+addr, 3 06 wr, 4 05 rd, 5 empty
        wr(8'h08, 16'h009F); wr(8'h09, 16'h0003); wr(8'h0A, 16'h0002);
        wr(8'h0B, 16'h0006); wr(8'h0C, 16'h0005);
        wr(8'h05, 16'h0078);
        wr(8'h04, 16'h5006);
        rd(8'h05, v); check(v == 16'h0078, "R4 type readback", int'(v), 16'h78);

        // R4 R5: read without address, 3 bytes
        exp_f = '{4}; exp_b = '{8'h9F, 8'h00, 8'h00, 8'h00};
        run_cycle(16'h4202, 1'b0, "R4 read id");
        for (int j = 0; j < 3; j++) begin
            rd(8'(8'h40 + j), v);
            check(v[7:0] == pat(1 + j), "R4 read data stored", int'(v), int'(pat(1 + j)));
        end

        // R3 R8: read with address, 8 bytes, second start while busy ignored
        wr(8'h02, 16'h3456); wr(8'h03, 16'h0012);
        exp_f = '{12}; exp_b = '{8'h03, 8'h12, 8'h34, 8'h56, 0, 0, 0, 0, 0, 0, 0, 0};
        run_cycle(16'h4712, 1'b1, "R3 R8 addressed read");
        rd(8'h01, v); check(v == 16'h4710, "R8 control unchanged", int'(v), 16'h4710);
        rd(8'h47, v); check(v[7:0] == pat(11), "R3 last read byte", int'(v), int'(pat(11)));

        // R6 R5: atomic write with address, 64 bytes, prefix 0
        for (int j = 0; j < 64; j++) wr(8'(8'h40 + j), 16'(j * 3 + 1));
        wr(8'h02, 16'hCDEF); wr(8'h03, 16'h00AB);
        exp_f = '{1, 68};
        exp_b = '{8'h06, 8'h02, 8'hAB, 8'hCD, 8'hEF};
        for (int j = 0; j < 64; j++) exp_b.push_back(8'(j * 3 + 1));
        run_cycle(16'h7F26, 1'b0, "R6 R5 atomic 64-byte write");
        check(min_gap >= CLK_DIV, "R6 gap between frames", min_gap, CLK_DIV);

        // R5: write without address, no data phase
        exp_f = '{1}; exp_b = '{8'h06};
        run_cycle(16'h0032, 1'b0, "R5 no data phase");

        // R6 R5: atomic with prefix 1, 1-byte read
        exp_f = '{1, 2}; exp_b = '{8'h50, 8'h05, 8'h00};
        run_cycle(16'h404E, 1'b0, "R6 prefix 1 atomic");
        rd(8'h40, v); check(v[7:0] == pat(1), "R5 single byte read", int'(v), int'(pat(1)));

        // R7: empty entry refused
        got_f.delete();
        wr(8'h01, 16'h0052);
        repeat (3 * CLK_DIV) @(negedge clk);
        rd(8'h00, v); check(v == 16'h0004, "R7 blocked flag only", int'(v), 4);
        check(got_f.size() == 0, "R7 no frame", got_f.size(), 0);

        // R9: write-one-to-clear
        wr(8'h00, 16'h0004);
        rd(8'h00, v); check(v == 16'h0000, "R9 W1C blocked", int'(v), 0);

        // R10: lock
        wr(8'h00, 16'h8000);
        rd(8'h00, v); check(v == 16'h8000, "R10 lock set", int'(v), 16'h8000);
        wr(8'h08, 16'h0011); wr(8'h05, 16'hFFFF); wr(8'h04, 16'h1234);
        rd(8'h08, v); check(v == 16'h009F, "R10 table frozen", int'(v), 16'h9F);
        rd(8'h05, v); check(v == 16'h0078, "R10 types frozen", int'(v), 16'h78);
        rd(8'h04, v); check(v == 16'h5006, "R10 prefixes frozen", int'(v), 16'h5006);
        wr(8'h00, 16'h0000);
        rd(8'h00, v); check(v[15] == 1'b1, "R10 lock sticky", int'(v), 16'h8000);

        // R11 R3: monitor results
        check(mon_err == 0, "R11 R3 SCK phases and idle", mon_err, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule